// File: doc/BRIEF.md
# Priority-Muxed GPIO Port Controller

This block is a general-purpose I/O port with four working pins (bit positions 7, 6, 1 and 0) behind a small register bus. Software sets a data value, a direction and a pull-up enable for each pin. It can read the latched data or the live pin levels.

Two peripherals can take over the upper pin pair. A CAN controller always wins. An I2C controller wins when CAN is off. Plain I/O gets the pins only when neither peripheral is enabled. Under I2C ownership both pins become open-drain. Under CAN ownership bit 7 drives the transmit line and bit 6 is a receive input.

Pin levels pass through a two-flop synchronizer before any read path or peripheral input sees them. Toward the pads the block produces, for each bit, an output value, an output enable, an open-drain flag and a pull-up enable.

Top module: `gpio_prio_port`

## Requirements
- R1: After reset, the data register reads 0x00, the direction register reads 0x00 and the pull-up register reads 0xC3. Every implemented pin has output enable 0 and pull-up 1.
- R2: While `can_en` is 1, bit 7 is push-pull with output value `can_tx`, output enable 1 and pull-up 0. Bit 6 is an input (output enable 0, open-drain 0) whose pull-up follows pull-up register bit 6. This holds whatever `i2c_en` is.
- R3: While `can_en` is 0 and `i2c_en` is 1, bits 7 and 6 carry SCL and SDA as open-drain outputs:
  - open-drain is 1 and output value is 0;
  - output enable is the inverse of `i2c_scl_o` (bit 7) and of `i2c_sda_o` (bit 6);
  - pull-up follows the pull-up register.
- R4: Bits 1 and 0 are always plain I/O. Bits 7 and 6 are plain I/O while both enables are 0. A plain I/O pin has output value equal to its data bit, output enable equal to its direction bit, and open-drain 0.
- R5: Bits 5 to 2 read as 0 in every register and ignore writes. Their pad outputs (value, enable, open-drain, pull-up) are always 0.
- R6: The data register (offset 0x28) is writable at any time. For each bit, a read returns the latched bit when the direction bit is 1 (output), and the synchronized pin level when it is 0.
- R7: The input register (offset 0x29) always returns the synchronized pin levels, whatever the direction. Writes to it change no register.
- R8: A pin change at the pad is visible on reads after exactly two rising clock edges, and not after one.
- R9: The pull-up of a plain I/O pin is its pull-up register bit when its direction is input, and 0 when its direction is output.
- R10: The direction register (offset 0x2A) and the pull-up register (offset 0x2B) read back what was written, masked to bits 7, 6, 1 and 0. Any other offset reads 0x00.
- R11: `can_rx` and `i2c_sda_i` equal synchronized pin bit 6, and `i2c_scl_i` equals synchronized pin bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Register offset |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| can_en | input | 1 | CAN controller enable |
| can_tx | input | 1 | CAN transmit value |
| can_rx | output | 1 | Synchronized CAN receive level |
| i2c_en | input | 1 | I2C controller enable |
| i2c_scl_o | input | 1 | I2C clock drive (0 pulls low) |
| i2c_sda_o | input | 1 | I2C data drive (0 pulls low) |
| i2c_scl_i | output | 1 | Synchronized SCL level |
| i2c_sda_i | output | 1 | Synchronized SDA level |
| pin_in | input | 8 | Pad input levels |
| pad_out | output | 8 | Pad output value |
| pad_oe | output | 8 | Pad output enable |
| pad_od | output | 8 | Pad open-drain select |
| pad_pu | output | 8 | Pad pull-up enable |

## Verification
Plain I/O is swept over every combination of four data bits and four direction bits, each against two complementary pin patterns. A lost pin-level path, a lost latched-data path or a swapped direction select each give a different wrong read value.

Ownership is swept over all 32 combinations of the two enables and the three peripheral drive values. This separates the CAN-over-I2C ordering, the open-drain inversion and the fall-back to plain I/O.

All-ones writes to every offset expose unimplemented bits and a writable input register. A pin edge sampled after one and after two clock edges pins down the synchronizer depth.

// File: rtl/gpio_prio_port.sv
module gpio_prio_port #(
  parameter int          AW       = 8,
  parameter int          DW       = 8,
  parameter logic [DW-1:0] IMPL   = 8'hC3,
  parameter logic [AW-1:0] A_DATA = 8'h28,
  parameter logic [AW-1:0] A_IN   = 8'h29,
  parameter logic [AW-1:0] A_DIR  = 8'h2A,
  parameter logic [AW-1:0] A_PU   = 8'h2B
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_we,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          can_en,
  input  logic          can_tx,
  output logic          can_rx,
  input  logic          i2c_en,
  input  logic          i2c_scl_o,
  input  logic          i2c_sda_o,
  output logic          i2c_scl_i,
  output logic          i2c_sda_i,
  input  logic [DW-1:0] pin_in,
  output logic [DW-1:0] pad_out,
  output logic [DW-1:0] pad_oe,
  output logic [DW-1:0] pad_od,
  output logic [DW-1:0] pad_pu
);
  localparam int HI = 7;
  localparam int LO = 6;

  logic [DW-1:0] data_q, dir_q, pu_q, sync1_q, sync2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= '0;
      dir_q   <= '0;
      pu_q    <= IMPL;
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      sync1_q <= pin_in & IMPL;
      sync2_q <= sync1_q;
      if (bus_we) begin
        if (bus_addr == A_DATA) data_q <= bus_wdata & IMPL;
        if (bus_addr == A_DIR)  dir_q  <= bus_wdata & IMPL;
        if (bus_addr == A_PU)   pu_q   <= bus_wdata & IMPL;
      end
    end
  end

  always_comb begin
    unique case (bus_addr)
      A_DATA:  bus_rdata = (dir_q & data_q) | (~dir_q & sync2_q);
      A_IN:    bus_rdata = sync2_q;
      A_DIR:   bus_rdata = dir_q;
      A_PU:    bus_rdata = pu_q;
      default: bus_rdata = '0;
    endcase
  end

  assign can_rx    = sync2_q[LO];
  assign i2c_sda_i = sync2_q[LO];
  assign i2c_scl_i = sync2_q[HI];

  always_comb begin
    pad_out = data_q & IMPL;
    pad_oe  = dir_q & IMPL;
    pad_od  = '0;
    pad_pu  = pu_q & ~dir_q & IMPL;
    if (can_en) begin
      pad_out[HI] = can_tx;
      pad_oe[HI]  = 1'b1;
      pad_pu[HI]  = 1'b0;
      pad_out[LO] = 1'b0;
      pad_oe[LO]  = 1'b0;
      pad_pu[LO]  = pu_q[LO];
    end else if (i2c_en) begin
      pad_out[HI] = 1'b0;
      pad_oe[HI]  = ~i2c_scl_o;
      pad_od[HI]  = 1'b1;
      pad_pu[HI]  = pu_q[HI];
      pad_out[LO] = 1'b0;
      pad_oe[LO]  = ~i2c_sda_o;
      pad_od[LO]  = 1'b1;
      pad_pu[LO]  = pu_q[LO];
    end
  end

  logic past_ok_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok_q <= 1'b0;
    else        past_ok_q <= 1'b1;
  end

  AST_SYNC_STAGE1: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok_q |-> sync1_q == ($past(pin_in) & IMPL)); // R8
  AST_SYNC_STAGE2: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok_q |-> sync2_q == $past(sync1_q)); // R8
  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && bus_addr == A_DATA) |=> $stable(data_q)); // R6
  AST_INPUT_NOWRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_IN) |=> $stable(dir_q) && $stable(pu_q) && $stable(data_q)); // R7
  AST_UNIMPL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_out | pad_oe | pad_od | pad_pu) & ~IMPL) == '0); // R5
  AST_OD_NEVER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_od & pad_oe & pad_out) == '0); // R3
  AST_PU_OFF_PUSHPULL: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_pu & pad_oe & ~pad_od) == '0); // R9
  AST_CAN_NO_OD: assert property (@(posedge clk) disable iff (!rst_n)
    can_en |-> pad_od[HI:LO] == 2'b00 && pad_oe[HI]); // R2
endmodule

// File: tb/gpio_prio_port_tb.sv
module gpio_prio_port_tb;
  localparam int CLK_P = 10;
  localparam logic [7:0] M = 8'hC3;

  logic clk = 0, rst_n = 0;
  logic [7:0] bus_addr = 0, bus_wdata = 0, pin_in = 0;
  logic bus_we = 0, can_en = 0, can_tx = 0, i2c_en = 0, i2c_scl_o = 1, i2c_sda_o = 1;
  logic [7:0] bus_rdata, pad_out, pad_oe, pad_od, pad_pu;
  logic can_rx, i2c_scl_i, i2c_sda_i;
  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  gpio_prio_port u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .can_en(can_en),
    .can_tx(can_tx), .can_rx(can_rx), .i2c_en(i2c_en), .i2c_scl_o(i2c_scl_o),
    .i2c_sda_o(i2c_sda_o), .i2c_scl_i(i2c_scl_i), .i2c_sda_i(i2c_sda_i),
    .pin_in(pin_in), .pad_out(pad_out), .pad_oe(pad_oe), .pad_od(pad_od),
    .pad_pu(pad_pu));

  function automatic logic [7:0] ex(input logic [3:0] x);
    return {x[3], x[2], 4'b0, x[1], x[0]};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1;
    @(negedge clk); bus_we = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [7:0] r, pu;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rd(8'h28, r); chk("R1 data", r, 8'h00);
    rd(8'h2A, r); chk("R1 dir", r, 8'h00);
    rd(8'h2B, r); chk("R1 pu", r, 8'hC3);
    chk("R1 oe", pad_oe, 8'h00);
    chk("R1 pu pads", pad_pu, 8'hC3);

    // R10 / R5: all-ones and other patterns into each register
    wr(8'h2A, 8'hFF); rd(8'h2A, r); chk("R10 R5 dir mask", r, M);
    wr(8'h2B, 8'h3C); rd(8'h2B, r); chk("R10 R5 pu mask", r, 8'h00);
    wr(8'h2B, 8'hFF); rd(8'h2B, r); chk("R10 pu", r, M);
    wr(8'h28, 8'hFF); rd(8'h28, r); chk("R5 data mask", r, M);
    rd(8'h30, r); chk("R10 other offset", r, 8'h00);
    // R7: write to input register ignored
    wr(8'h29, 8'h00);
    rd(8'h28, r); chk("R7 data unchanged", r, M);
    rd(8'h2A, r); chk("R7 dir unchanged", r, M);
    rd(8'h2B, r); chk("R7 pu unchanged", r, M);

    // R8 latency
    wr(8'h2A, 8'h00);
    pin_in = 8'h00; repeat (3) @(negedge clk);
    pin_in = 8'hFF; @(negedge clk);
    rd(8'h29, r); chk("R8 one edge", r, 8'h00);
    @(negedge clk);
    rd(8'h29, r); chk("R8 two edges", r, M);
    chk("R11 can_rx", can_rx, 1'b1);
    chk("R11 scl_i", i2c_scl_i, 1'b1);
    chk("R11 sda_i", i2c_sda_i, 1'b1);
    pin_in = 8'h40; repeat (2) @(negedge clk);
    chk("R11 scl_i low", i2c_scl_i, 1'b0);
    chk("R11 sda_i hi", i2c_sda_i, 1'b1);

    // R4 R6 R9 R5 sweep
    pu = 8'h82;
    wr(8'h2B, pu);
    for (int d = 0; d < 16; d++) begin
      for (int dr = 0; dr < 16; dr++) begin
        wr(8'h28, ex(d[3:0]));
        wr(8'h2A, ex(dr[3:0]));
        for (int p = 0; p < 2; p++) begin
          pin_in = p ? 8'h5A : 8'hA5;
          repeat (2) @(negedge clk);
          rd(8'h28, r);
          chk("R6 data read", r, ((ex(dr[3:0]) & ex(d[3:0])) | (~ex(dr[3:0]) & pin_in)) & M);
          rd(8'h29, r);
          chk("R7 input read", r, pin_in & M);
          chk("R4 pad_out", pad_out, ex(d[3:0]));
          chk("R4 pad_oe", pad_oe, ex(dr[3:0]));
          chk("R4 pad_od", pad_od, 8'h00);
          chk("R9 pad_pu", pad_pu, pu & ~ex(dr[3:0]) & M);
        end
      end
    end

    // R2 R3 R4 priority sweep
    wr(8'h28, 8'h41); wr(8'h2A, 8'h83); wr(8'h2B, 8'hC3);
    for (int c = 0; c < 32; c++) begin
      logic [7:0] eo, ee, ed, ep;
      @(negedge clk);
      {can_en, i2c_en, can_tx, i2c_scl_o, i2c_sda_o} = c[4:0];
      #1;
      eo = 8'h41; ee = 8'h83; ed = 8'h00; ep = 8'hC3 & ~8'h83;
      if (can_en) begin
        eo[7] = can_tx; ee[7] = 1; ep[7] = 0;
        eo[6] = 0; ee[6] = 0; ep[6] = 1;
      end else if (i2c_en) begin
        eo[7] = 0; ee[7] = ~i2c_scl_o; ed[7] = 1; ep[7] = 1;
        eo[6] = 0; ee[6] = ~i2c_sda_o; ed[6] = 1; ep[6] = 1;
      end
      chk(can_en ? "R2 out" : i2c_en ? "R3 out" : "R4 out", pad_out, eo);
      chk(can_en ? "R2 oe" : i2c_en ? "R3 oe" : "R4 oe", pad_oe, ee);
      chk(can_en ? "R2 od" : i2c_en ? "R3 od" : "R4 od", pad_od, ed);
      chk(can_en ? "R2 pu" : i2c_en ? "R3 pu" : "R9 pu", pad_pu, ep);
    end
    finish_run();
  end
endmodule